// File: doc/BRIEF.md
# Paged Address Translator with Access Checking

This block sits between a CPU and its memory decode. Every request carries a logical address, a write flag and a privilege flag. Addresses in the low 4 MB RAM window are split into 4 KB pages. The ten page-number bits select one 16-bit entry in an internal page table. The entry supplies a physical page number, two page-status bits and a write-enable bit. The same entry decides whether the access is permitted.

User-mode requests are screened by a fixed sequence of rules. When a request is refused, the block reports a fault class. For some fault classes it also emits a general-status word for the system to latch. Supervisor requests are never refused.

When an access is permitted and its page is marked present, the block writes accessed/dirty marks back into the page table entry. The CPU loads entries through a separate table port. That port also returns the entry it is pointed at, so software can see the marks. Raising the bus error and the backing memory are left to neighbouring logic.

Top module: `page_mmu`

## Requirements
- R1: During and after synchronous reset every output is zero and every page table entry reads back as zero.
- R2: A request seen on a rising edge produces rsp_valid in the following cycle. A permitted access below 0x400000 gives rsp_phys = {2'b00, entry[9:0], addr[11:0]}, where the entry is selected by addr[21:12]. A cycle without a request gives rsp_valid = 0 next cycle.
- R3: A permitted access at or above 0x400000 returns the logical address unchanged on rsp_phys.
- R4: A supervisor request (req_super = 1) is always permitted, whatever the page status, write-enable bit or address region. rsp_ok = 1 and rsp_fault = 0.
- R5: A user request at or above 0x400000 is refused with rsp_fault = 1 (non-memory). It raises gstat_we with code 0x9EFF for a write and 0xDEFF for a read.
- R6: A user request to a page whose status bits entry[14:13] are 00 is refused with rsp_fault = 2 (page absent). It raises gstat_we with code 0x8FFF for a write and 0xCFFF for a read.
- R7: A user request to a present page whose addr[22:19] are all zero is refused with rsp_fault = 3 (kernel region). gstat_we stays low.
- R8: A user write to a present, non-kernel page whose entry bit 15 is 0 is refused with rsp_fault = 4 (write-protected). gstat_we stays low. A user read of the same page is permitted.
- R9: The user checks take priority in this order: non-memory, page absent, kernel region, write-protected.
- R10: A permitted access below 0x400000 to a page with non-zero status sets entry bit 14 on a read, and bits 14 and 13 on a write. A page with status 00 is left unmodified.
- R11: A refused access leaves its page table entry unchanged. It holds rsp_ok at 0 and rsp_phys at zero.
- R12: A table write (map_we) updates the entry on the rising edge. A request on that same edge still uses the old entry. If both the table write and a status-mark update target one entry, the table write wins.
- R13: map_rdata always shows the current content of the entry selected by map_idx, combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Access request present this cycle |
| req_addr | input | 24 | Logical byte address |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_super | input | 1 | 1 = supervisor privilege |
| map_we | input | 1 | Write map_wdata into the entry at map_idx |
| map_idx | input | 10 | Page table entry index for write and read-back |
| map_wdata | input | 16 | Entry value to store |
| map_rdata | output | 16 | Current entry at map_idx |
| rsp_valid | output | 1 | Result of last cycle's request |
| rsp_ok | output | 1 | Access permitted; rsp_phys is meaningful |
| rsp_fault | output | 3 | 0 none, 1 non-memory, 2 page absent, 3 kernel region, 4 write-protected |
| rsp_phys | output | 24 | Translated physical address |
| gstat_we | output | 1 | Latch gstat_code into the general-status register |
| gstat_code | output | 16 | General-status word for the refused access |

## Verification
The response of a request is registered, so the bench checks the response fields one cycle after the edge that sampled the request. Page table changes from status marks and table writes land on that same edge. Because map_rdata is combinational, these changes are read back through map_rdata in that same post-edge window. The bench drives inputs on the falling edge and samples one time unit after each rising edge. On every cycle it compares all outputs against a behavioural page table model. The model applies each status mark before the table write of the same cycle.

// File: rtl/pmmu_pkg.sv
package pmmu_pkg;

    localparam int ENTRY_W = 16;
    localparam int WE_BIT  = 15;
    localparam int ST_HI   = 14;
    localparam int ST_LO   = 13;
    localparam int CODE_W  = 16;

    typedef logic [ENTRY_W-1:0] entry_t;

    localparam entry_t MARK_READ  = 16'h4000;
    localparam entry_t MARK_WRITE = 16'h6000;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_NONMEM = 3'd1,
        FLT_PAGE   = 3'd2,
        FLT_KERNEL = 3'd3,
        FLT_WPROT  = 3'd4
    } fault_e;

    typedef struct packed {
        logic              ok;
        fault_e            fault;
        logic              mark;
        entry_t            marked;
        logic              gs_we;
        logic [CODE_W-1:0] gs_code;
    } verdict_t;

    function automatic logic [CODE_W-1:0] status_word(input fault_e f, input logic wr);
        case (f)
            FLT_NONMEM: return wr ? 16'h9EFF : 16'hDEFF;
            FLT_PAGE:   return wr ? 16'h8FFF : 16'hCFFF;
            default:    return '0;
        endcase
    endfunction

endpackage

// File: rtl/pmmu_check.sv
module pmmu_check
    import pmmu_pkg::*;
#(
    parameter int                ADDR_W    = 24,
    parameter int                PN_W      = 10,
    parameter int                OFS_W     = 12,
    parameter int                KERN_LO   = 19,
    parameter int                KERN_HI   = 22,
    parameter logic [ADDR_W-1:0] RAM_LIMIT = 24'h40_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              sup,
    input  entry_t            entry,
    output verdict_t          verdict,
    output logic [ADDR_W-1:0] phys
);
    localparam int ZW = ADDR_W - PN_W - OFS_W;

    logic   in_ram;
    logic   present;
    logic   kernel_zone;
    fault_e fault;

    assign in_ram      = addr < RAM_LIMIT;
    assign present     = |entry[ST_HI:ST_LO];
    assign kernel_zone = ~|addr[KERN_HI:KERN_LO];

    // user-mode rules, first match decides
    always_comb begin
        fault = FLT_NONE;
        if (!sup) begin
            if (!in_ram)                    fault = FLT_NONMEM;
            else if (!present)              fault = FLT_PAGE;
            else if (kernel_zone)           fault = FLT_KERNEL;
            else if (wr && !entry[WE_BIT])  fault = FLT_WPROT;
        end
        verdict.ok      = (fault == FLT_NONE);
        verdict.fault   = fault;
        verdict.mark    = verdict.ok && in_ram && present;
        verdict.marked  = entry | (wr ? MARK_WRITE : MARK_READ);
        verdict.gs_code = status_word(fault, wr);
        verdict.gs_we   = (fault == FLT_NONMEM) || (fault == FLT_PAGE);
    end

    assign phys = in_ram ? {{ZW{1'b0}}, entry[PN_W-1:0], addr[OFS_W-1:0]} : addr;

endmodule

// File: rtl/pmmu_map_ram.sv
module pmmu_map_ram
    import pmmu_pkg::*;
#(
    parameter int PN_W = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cpu_we,
    input  logic [PN_W-1:0] cpu_idx,
    input  entry_t          cpu_wdata,
    input  logic            upd_we,
    input  logic [PN_W-1:0] upd_idx,
    input  entry_t          upd_data,
    input  logic [PN_W-1:0] look_idx,
    output entry_t          look_entry,
    output entry_t          cpu_rdata
);
    localparam int DEPTH = 1 << PN_W;

    entry_t mem [DEPTH];

    // status marks first, table write last so it wins on a shared index
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (upd_we) mem[upd_idx] <= upd_data;
            if (cpu_we) mem[cpu_idx] <= cpu_wdata;
        end
    end

    assign look_entry = mem[look_idx];
    assign cpu_rdata  = mem[cpu_idx];

    assert_cpu_wins_R12: assert property (@(posedge clk) disable iff (rst)
        (cpu_we) |=> (mem[$past(cpu_idx)] == $past(cpu_wdata)));

    assert_mark_lands_R10: assert property (@(posedge clk) disable iff (rst)
        (upd_we && !(cpu_we && cpu_idx == upd_idx)) |=> (mem[$past(upd_idx)] == $past(upd_data)));

endmodule

// File: rtl/page_mmu.sv
module page_mmu
    import pmmu_pkg::*;
#(
    parameter int                ADDR_W    = 24,
    parameter int                PN_W      = 10,
    parameter int                OFS_W     = 12,
    parameter int                KERN_LO   = 19,
    parameter int                KERN_HI   = 22,
    parameter logic [ADDR_W-1:0] RAM_LIMIT = 24'h40_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_super,
    input  logic              map_we,
    input  logic [PN_W-1:0]   map_idx,
    input  logic [15:0]       map_wdata,
    output logic [15:0]       map_rdata,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic [2:0]        rsp_fault,
    output logic [ADDR_W-1:0] rsp_phys,
    output logic              gstat_we,
    output logic [15:0]       gstat_code
);
    logic [PN_W-1:0]   page;
    entry_t            entry;
    verdict_t          verdict;
    logic [ADDR_W-1:0] phys;
    logic              upd_we;

    assign page   = req_addr[OFS_W+PN_W-1:OFS_W];
    assign upd_we = req_valid && verdict.mark;

    pmmu_map_ram #(.PN_W(PN_W)) u_map (
        .clk        (clk),
        .rst        (rst),
        .cpu_we     (map_we),
        .cpu_idx    (map_idx),
        .cpu_wdata  (map_wdata),
        .upd_we     (upd_we),
        .upd_idx    (page),
        .upd_data   (verdict.marked),
        .look_idx   (page),
        .look_entry (entry),
        .cpu_rdata  (map_rdata)
    );

    pmmu_check #(
        .ADDR_W(ADDR_W), .PN_W(PN_W), .OFS_W(OFS_W),
        .KERN_LO(KERN_LO), .KERN_HI(KERN_HI), .RAM_LIMIT(RAM_LIMIT)
    ) u_check (
        .addr    (req_addr),
        .wr      (req_write),
        .sup     (req_super),
        .entry   (entry),
        .verdict (verdict),
        .phys    (phys)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_ok     <= 1'b0;
            rsp_fault  <= FLT_NONE;
            rsp_phys   <= '0;
            gstat_we   <= 1'b0;
            gstat_code <= '0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_ok     <= req_valid && verdict.ok;
            rsp_fault  <= req_valid ? verdict.fault : FLT_NONE;
            rsp_phys   <= (req_valid && verdict.ok) ? phys : '0;
            gstat_we   <= req_valid && verdict.gs_we;
            gstat_code <= (req_valid && verdict.gs_we) ? verdict.gs_code : '0;
        end
    end

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (!req_valid) |=> (!rsp_valid && !gstat_we));

    assert_offset_kept_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_super && req_addr < RAM_LIMIT)
            |=> (rsp_phys[OFS_W-1:0] == $past(req_addr[OFS_W-1:0])));

    assert_super_ok_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_super) |=> (rsp_ok && rsp_fault == 3'd0));

    assert_nonmem_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_super && req_addr >= RAM_LIMIT)
            |=> (rsp_fault == 3'd1 && gstat_we));

    assert_gstat_on_fault_R11: assert property (@(posedge clk) disable iff (rst)
        gstat_we |-> (rsp_valid && !rsp_ok));

endmodule

// File: tb/test_page_mmu.sv
module test_page_mmu;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_super = 1'b0;
    logic        map_we = 1'b0;
    logic [9:0]  map_idx = '0;
    logic [15:0] map_wdata = '0;
    logic [15:0] map_rdata;
    logic        rsp_valid, rsp_ok, gstat_we;
    logic [2:0]  rsp_fault;
    logic [23:0] rsp_phys;
    logic [15:0] gstat_code;

    int n_tests = 0;
    int n_fail  = 0;
    int model [1024];

    always #(CLK_PERIOD/2) clk = ~clk;

    page_mmu i_page_mmu (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write), .req_super(req_super),
        .map_we(map_we), .map_idx(map_idx), .map_wdata(map_wdata), .map_rdata(map_rdata),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_fault(rsp_fault), .rsp_phys(rsp_phys),
        .gstat_we(gstat_we), .gstat_code(gstat_code)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // one clock: drive on falling edge, predict, compare after the rising edge
    task automatic step(input string tag, input bit v, input int addr, input bit wr, input bit sup,
                        input bit mwe, input int midx, input int mwd);
        int pg, ent, st, flt, e_ok, e_phys, e_gwe, e_gc;
        @(negedge clk);
        req_valid = v; req_addr = addr[23:0]; req_write = wr; req_super = sup;
        map_we = mwe; map_idx = midx[9:0]; map_wdata = mwd[15:0];
        pg = (addr >> 12) & 1023;
        ent = model[pg];
        st = (ent >> 13) & 3;
        flt = 0; e_ok = 0; e_phys = 0; e_gwe = 0; e_gc = 0;
        if (v) begin
            if (sup)                                flt = 0;
            else if (addr >= 'h400000)              flt = 1;
            else if (st == 0)                       flt = 2;
            else if (((addr >> 19) & 15) == 0)      flt = 3;
            else if (wr && ((ent >> 15) & 1) == 0)  flt = 4;
            if (flt == 0) begin
                e_ok = 1;
                if (addr < 'h400000) begin
                    e_phys = ((ent & 1023) << 12) | (addr & 'hFFF);
                    if (st != 0) model[pg] = ent | (wr ? 'h6000 : 'h4000);
                end else begin
                    e_phys = addr;
                end
            end
            if (flt == 1) begin e_gwe = 1; e_gc = wr ? 'h9EFF : 'hDEFF; end
            if (flt == 2) begin e_gwe = 1; e_gc = wr ? 'h8FFF : 'hCFFF; end
        end
        if (mwe) model[midx & 1023] = mwd & 'hFFFF;
        @(posedge clk);
        #1;
        chk(tag, "rsp_valid",  int'(rsp_valid),  int'(v));
        chk(tag, "rsp_ok",     int'(rsp_ok),     e_ok);
        chk(tag, "rsp_fault",  int'(rsp_fault),  flt);
        chk(tag, "rsp_phys",   int'(rsp_phys),   e_phys);
        chk(tag, "gstat_we",   int'(gstat_we),   e_gwe);
        chk(tag, "gstat_code", int'(gstat_code), e_gc);
        chk(tag, "map_rdata",  int'(map_rdata),  model[midx & 1023]);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) model[i] = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "rsp_valid in reset", int'(rsp_valid), 0);
        chk("R1", "map_rdata in reset", int'(map_rdata), 0);
        @(negedge clk);
        rst = 1'b0;
        step("R1", 0, 0, 0, 0, 0, 'h000, 0);
        step("R1", 0, 0, 0, 0, 0, 'h3FF, 0);

        // load entries: {WE, status[1:0], ..., ppn[9:0]}
        step("R13", 0, 0, 0, 0, 1, 'h100, 'hA2A5);
        step("R13", 0, 0, 0, 0, 1, 'h101, 'h2011);
        step("R13", 0, 0, 0, 0, 1, 'h020, 'hA033);
        step("R13", 0, 0, 0, 0, 1, 'h021, 'h2044);
        step("R13", 0, 0, 0, 0, 1, 'h200, 'h8155);
        step("R13", 0, 0, 0, 0, 1, 'h3FF, 'hA001);

        // translation and status marks
        step("R2",  1, 'h100ABC, 0, 0, 0, 'h100, 0);
        step("R10", 1, 'h3FF123, 1, 0, 0, 'h3FF, 0);
        step("R2",  0, 'h100ABC, 0, 0, 0, 'h100, 0);

        // write protect, reads still allowed
        step("R8",  1, 'h101000, 1, 0, 0, 'h101, 0);
        step("R8",  1, 'h101004, 0, 0, 0, 'h101, 0);

        // page absent
        step("R6",  1, 'h200000, 0, 0, 0, 'h200, 0);
        step("R6",  1, 'h200010, 1, 0, 0, 'h200, 0);

        // non-memory
        step("R5",  1, 'h400000, 0, 0, 0, 'h000, 0);
        step("R5",  1, 'hE43000, 1, 0, 0, 'h000, 0);

        // kernel region
        step("R7",  1, 'h020010, 0, 0, 0, 'h020, 0);
        step("R7",  1, 'h020010, 1, 0, 0, 'h020, 0);

        // priority
        step("R9",  1, 'h021000, 1, 0, 0, 'h021, 0);
        step("R9",  1, 'h022000, 0, 0, 0, 'h022, 0);
        step("R9",  1, 'h7FFFFF, 1, 0, 0, 'h3FF, 0);
        step("R11", 1, 'h021008, 1, 0, 0, 'h021, 0);

        // supervisor
        step("R4",  1, 'h200000, 0, 1, 0, 'h200, 0);
        step("R4",  1, 'h101010, 1, 1, 0, 'h101, 0);
        step("R4",  1, 'h022000, 1, 1, 0, 'h022, 0);
        step("R4",  1, 'h020040, 1, 1, 0, 'h020, 0);

        // pass-through above the RAM window
        step("R3",  1, 'h800123, 0, 1, 0, 'h000, 0);
        step("R3",  1, 'hFFFFFF, 1, 1, 0, 'h000, 0);

        // same-edge table write against a request
        step("R12", 1, 'h100000, 0, 0, 1, 'h100, 'h2333);
        step("R12", 1, 'h100000, 0, 0, 0, 'h100, 0);
        step("R12", 1, 'h3FF000, 0, 0, 1, 'h3FF, 'h0000);
        step("R12", 1, 'h3FF000, 0, 0, 0, 'h3FF, 0);
        step("R12", 1, 'h101000, 0, 0, 1, 'h200, 'hA077);
        step("R12", 1, 'h200000, 1, 0, 0, 'h200, 0);

        step("R2",  0, 0, 0, 0, 0, 'h000, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule